// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Hold

This block is a register-programmed SPI master with one transmit holding register and one receive register. Software configures a clock prescaler, a select-to-clock setup delay, a clock-to-deselect tail delay and the idle level of each chip-select line. It then writes data words. Each write carries an 8-bit payload, a chip-select number and a hold flag, and that write queues a transfer. The engine drives a mode-0 serial clock (idle low, first bit valid before the first rising edge) and shifts most significant bit first in both directions. The received byte and the buffer flags are reported in one status word.

With the hold flag set, chip select stays asserted after the word ends. A next word queued for the same select then shifts without a setup delay and with no break in the clock rhythm. Words without hold, or a next word for a different select, release the line after the tail delay. Reading status consumes the received byte. A byte that arrives before the previous one was read replaces it and raises an overrun flag.

Top module: `spi_hold_master`

## Requirements
- R1: The block is held inert unless run (address 0 bit 0, reset 0), master (address 1 bit 0) and enable (address 1 bit 1) are all 1. While held, transmit writes are ignored, status bits [2:0] read 3'b010, no clock edge is produced and select lines sit at their idle level.
- R2: A write to address 5 queues a word: payload in bits [7:0], select number in bits [18:16], hold flag in bit 24. Status bit 0 (transmit full) reads 1 from that write until the engine takes the word.
- R3: With prescale P (address 2, bits [7:0]) and T = max(P,1), the serial clock has a period of T+1 input clocks, low for ceil((T+1)/2) and high for the rest. It idles low, and every bit starts with the clock low.
- R4: Eight bits per word, MSB first on both lines; MOSI changes only while the clock is low, and MISO is captured while the clock is high.
- R5: From select assertion to the first rising edge there are D1 + ceil((T+1)/2) input clocks, where D1 is address 3 bits [7:0].
- R6: Without hold, select deasserts D2 input clocks after the last falling edge, where D2 is address 3 bits [15:8].
- R7: A word with hold set leaves its select asserted indefinitely. A next word for the same select shifts with no setup delay, and the rising edges of the two words stay evenly spaced.
- R8: Address 4 bit i gives the idle level of select line i. An asserted line carries the inverse level, and a select number with no matching line asserts none.
- R9: When a word completes, status bit 1 (receive empty) clears and status bits [15:8] hold the received byte.
- R10: A read strobe on address 6 sets receive empty and clears overrun (status bit 2). A word completing while receive empty is clear overwrites the byte and sets overrun.
- R11: A transmit write while transmit full is 1 is dropped, and the pending word is unchanged.
- R12: If a held select is followed by a word for a different select, the held line deasserts after the tail delay, and the new word then runs with its own setup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only on status) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Chip-select lines |

## Verification
A transmit write taken at clock edge k reaches the engine at edge k+1, so transmit full is sampled in the low phase straight after the write. Select assertion and the first rising edge are then D1 + ceil((T+1)/2) edges apart, and the final falling edge precedes deassertion by D2 edges. The bench timestamps select and clock transitions and compares their differences with these counts in whole clock periods. Buffer flags and received bytes are sampled only after a fixed drain time, which is longer than the complete transfer computed from P, D1 and D2.

// File: rtl/spi_hold_pkg.sv
// Package: shared register map, field positions and engine state type
// for the SPI master with per-word select hold. Assumes word addressing.
package spi_hold_pkg;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_FMT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DLY   = 3'd3;
    localparam logic [ADDR_W-1:0] A_IDLE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXD   = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

    localparam int TX_CSN_LSB   = 16;
    localparam int TX_HOLD_BIT  = 24;
    localparam int DLY_TAIL_LSB = 8;
    localparam int ST_RX_LSB    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HELD,
        ST_TAIL
    } eng_state_t;
endpackage

// File: rtl/spi_hold_regs.sv
// Register file: control, format, delay and idle-select registers, the
// single transmit holding word and the receive byte with its flags.
// Assumes DATA_W <= 16 and CSN_W <= 8 so fields do not overlap.
module spi_hold_regs
    import spi_hold_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int NUM_CS = 1,
    parameter int CSN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              active,
    output logic [PRE_W-1:0]  prescale,
    output logic [DLY_W-1:0]  cs2tx,
    output logic [DLY_W-1:0]  tx2cs,
    output logic [NUM_CS-1:0] idle_lvl,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_payload,
    output logic              tx_hold,
    output logic [CSN_W-1:0]  tx_csn,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data
);
    logic              run_q;
    logic              master_q;
    logic              ena_q;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_empty;
    logic              overrun_q;
    logic              stat_rd;
    logic              tx_wr;
    logic              unused_wdata;

    assign active       = run_q & master_q & ena_q;
    assign stat_rd      = bus_rd && (bus_addr == A_STAT);
    assign tx_wr        = bus_wr && (bus_addr == A_TXD);
    assign unused_wdata = ^bus_wdata;

    // Configuration registers, written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            master_q <= 1'b0;
            ena_q    <= 1'b0;
            prescale <= '0;
            cs2tx    <= '0;
            tx2cs    <= '0;
            idle_lvl <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL0: run_q <= bus_wdata[0];
                A_CTRL1: begin
                    master_q <= bus_wdata[0];
                    ena_q    <= bus_wdata[1];
                end
                A_FMT:   prescale <= bus_wdata[PRE_W-1:0];
                A_DLY: begin
                    cs2tx <= bus_wdata[DLY_W-1:0];
                    tx2cs <= bus_wdata[DLY_TAIL_LSB +: DLY_W];
                end
                A_IDLE:  idle_lvl <= bus_wdata[NUM_CS-1:0];
                default: ;
            endcase
        end
    end

    // Transmit holding word: filled by a bus write when empty, drained by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid   <= 1'b0;
            tx_payload <= '0;
            tx_hold    <= 1'b0;
            tx_csn     <= '0;
        end else if (!active) begin
            tx_valid <= 1'b0;
        end else if (tx_pop) begin
            tx_valid <= 1'b0;
        end else if (tx_wr && !tx_valid) begin
            tx_valid   <= 1'b1;
            tx_payload <= bus_wdata[DATA_W-1:0];
            tx_hold    <= bus_wdata[TX_HOLD_BIT];
            tx_csn     <= bus_wdata[TX_CSN_LSB +: CSN_W];
        end
    end

    // Receive byte and flags: a completed word fills it, a status read drains it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_empty  <= 1'b1;
            overrun_q <= 1'b0;
        end else if (!active) begin
            rx_empty  <= 1'b1;
            overrun_q <= 1'b0;
        end else if (rx_push) begin
            rx_buf    <= rx_data;
            rx_empty  <= 1'b0;
            overrun_q <= !rx_empty && !stat_rd;
        end else if (stat_rd) begin
            rx_empty  <= 1'b1;
            overrun_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL0: bus_rdata[0] = run_q;
            A_CTRL1: bus_rdata[1:0] = {ena_q, master_q};
            A_FMT:   bus_rdata[PRE_W-1:0] = prescale;
            A_DLY: begin
                bus_rdata[DLY_W-1:0]              = cs2tx;
                bus_rdata[DLY_TAIL_LSB +: DLY_W]  = tx2cs;
            end
            A_IDLE:  bus_rdata[NUM_CS-1:0] = idle_lvl;
            A_STAT: begin
                bus_rdata[0]                     = tx_valid;
                bus_rdata[1]                     = rx_empty;
                bus_rdata[2]                     = overrun_q;
                bus_rdata[ST_RX_LSB +: DATA_W]   = rx_buf;
            end
            default: ;
        endcase
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tx_valid && !tx_pop && tx_wr && !(bus_wr && bus_addr != A_TXD))
        |=> (tx_valid && $stable(tx_payload) && $stable(tx_hold) && $stable(tx_csn))); // R11

    AST_RX_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rx_push) |=> !rx_empty); // R9

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rx_push && !rx_empty && !stat_rd) |=> overrun_q); // R10

    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && stat_rd && !rx_push) |=> (rx_empty && !overrun_q)); // R10
endmodule

// File: rtl/spi_hold_bittimer.sv
// Bit timer: divides the module clock into serial-clock bit periods of
// max(prescale,1)+1 cycles, low phase first. Assumes en is held for whole
// words; the phase counter restarts whenever en is low.
module spi_hold_bittimer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] prescale,
    output logic             sclk,
    output logic             sample,
    output logic             bit_end
);
    localparam int CW = PRE_W + 1;

    logic [CW-1:0] top;
    logic [CW-1:0] len;
    logic [CW-1:0] low_len;
    logic [CW-1:0] pc;

    assign top     = (prescale == '0) ? CW'(1) : {1'b0, prescale};
    assign len     = top + CW'(1);
    assign low_len = len - (len >> 1);

    // Phase counter inside one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pc <= '0;
        end else if (pc == top) begin
            pc <= '0;
        end else begin
            pc <= pc + CW'(1);
        end
    end

    assign sclk    = en && (pc >= low_len);
    assign sample  = en && (pc == low_len);
    assign bit_end = en && (pc == top);

    AST_BIT_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !sclk); // R3

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> !sclk); // R3
endmodule

// File: rtl/spi_hold_engine.sv
// Transfer engine: takes words from the holding register, asserts the
// addressed select, waits the setup delay, shifts MSB first in mode 0,
// then holds or releases the select after the tail delay.
// Assumes the bit timer is enabled exactly while in the shift state.
module spi_hold_engine
    import spi_hold_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8,
    parameter int NUM_CS = 1,
    parameter int CSN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [DLY_W-1:0]  cs2tx,
    input  logic [DLY_W-1:0]  tx2cs,
    input  logic [NUM_CS-1:0] idle_lvl,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_payload,
    input  logic              tx_hold,
    input  logic [CSN_W-1:0]  tx_csn,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              sclk,
    input  logic              sample,
    input  logic              bit_end,
    output logic              shift_en,
    input  logic              miso,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    eng_state_t        state;
    logic [DLY_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic              cur_hold;
    logic [CSN_W-1:0]  cur_csn;
    logic              word_done;
    logic              same_cs;
    logic              do_load;

    assign word_done = (state == ST_SHIFT) && bit_end && (bitn == LAST_BIT);
    assign same_cs   = (tx_csn == cur_csn);
    assign rx_next   = {rx_sh[DATA_W-2:0], miso};
    assign rx_data   = sample ? rx_next : rx_sh;
    assign rx_push   = word_done;
    assign tx_pop    = do_load;
    assign shift_en  = (state == ST_SHIFT);
    assign mosi      = (state == ST_IDLE) ? 1'b0 : tx_sh[DATA_W-1];

    // Decide when a pending word is taken into the shifter.
    always_comb begin
        do_load = 1'b0;
        case (state)
            ST_IDLE:  do_load = tx_valid;
            ST_HELD:  do_load = tx_valid && same_cs;
            ST_SHIFT: do_load = word_done && cur_hold && tx_valid && same_cs;
            default:  do_load = 1'b0;
        endcase
    end

    // Sequencer, delay counter and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            cur_hold <= 1'b0;
            cur_csn  <= '0;
        end else begin
            if (do_load) begin
                tx_sh    <= tx_payload;
                cur_hold <= tx_hold;
                cur_csn  <= tx_csn;
                bitn     <= '0;
            end
            if ((state == ST_SHIFT) && sample) begin
                rx_sh <= rx_next;
            end
            case (state)
                ST_IDLE: begin
                    if (tx_valid) begin
                        if (cs2tx != '0) begin
                            state <= ST_SETUP;
                            cnt   <= cs2tx;
                        end else begin
                            state <= ST_SHIFT;
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt <= DLY_W'(1)) state <= ST_SHIFT;
                    else                  cnt   <= cnt - DLY_W'(1);
                end
                ST_SHIFT: begin
                    if (bit_end) begin
                        if (bitn == LAST_BIT) begin
                            if (!do_load) bitn <= '0;
                            if (do_load) begin
                                state <= ST_SHIFT;
                            end else if (cur_hold) begin
                                state <= ST_HELD;
                            end else if (tx2cs != '0) begin
                                state <= ST_TAIL;
                                cnt   <= tx2cs;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            bitn  <= bitn + BIT_W'(1);
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_HELD: begin
                    if (tx_valid) begin
                        if (same_cs) begin
                            state <= ST_SHIFT;
                        end else if (tx2cs != '0) begin
                            state <= ST_TAIL;
                            cnt   <= tx2cs;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_TAIL: begin
                    if (cnt <= DLY_W'(1)) state <= ST_IDLE;
                    else                  cnt   <= cnt - DLY_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One select driver per line: inverse of the idle level while addressed.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign cs_n[gi] = ((state != ST_IDLE) && (cur_csn == CSN_W'(gi)))
                          ? ~idle_lvl[gi] : idle_lvl[gi];
    end

    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R4

    AST_TAIL_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && word_done && !cur_hold && tx2cs != '0)
        |=> (!active || !$stable(idle_lvl) || cs_n == $past(cs_n))); // R6

    AST_HELD_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == ST_HELD && !tx_valid)
        |=> (!active || !$stable(idle_lvl) || cs_n == $past(cs_n))); // R7
endmodule

// File: rtl/spi_hold_master.sv
// Top level: register-programmed SPI master with one transmit holding
// word, one receive byte and per-word select hold. Assumes a single
// module clock with synchronous active-low reset.
module spi_hold_master
    import spi_hold_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 8,
    parameter int DLY_W  = 8,
    parameter int NUM_CS = 1,
    parameter int CSN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic              active;
    logic [PRE_W-1:0]  prescale;
    logic [DLY_W-1:0]  cs2tx;
    logic [DLY_W-1:0]  tx2cs;
    logic [NUM_CS-1:0] idle_lvl;
    logic              tx_valid;
    logic [DATA_W-1:0] tx_payload;
    logic              tx_hold;
    logic [CSN_W-1:0]  tx_csn;
    logic              tx_pop;
    logic              rx_push;
    logic [DATA_W-1:0] rx_data;
    logic              shift_en;
    logic              sample;
    logic              bit_end;

    spi_hold_regs #(
        .DATA_W(DATA_W), .PRE_W(PRE_W), .DLY_W(DLY_W),
        .NUM_CS(NUM_CS), .CSN_W(CSN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .active(active), .prescale(prescale), .cs2tx(cs2tx), .tx2cs(tx2cs),
        .idle_lvl(idle_lvl), .tx_valid(tx_valid), .tx_payload(tx_payload),
        .tx_hold(tx_hold), .tx_csn(tx_csn), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data)
    );

    spi_hold_bittimer #(.PRE_W(PRE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .prescale(prescale),
        .sclk(spi_sclk), .sample(sample), .bit_end(bit_end)
    );

    spi_hold_engine #(
        .DATA_W(DATA_W), .DLY_W(DLY_W), .NUM_CS(NUM_CS), .CSN_W(CSN_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .active(active),
        .cs2tx(cs2tx), .tx2cs(tx2cs), .idle_lvl(idle_lvl),
        .tx_valid(tx_valid), .tx_payload(tx_payload), .tx_hold(tx_hold),
        .tx_csn(tx_csn), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
        .sclk(spi_sclk), .sample(sample), .bit_end(bit_end), .shift_en(shift_en),
        .miso(spi_miso), .mosi(spi_mosi), .cs_n(spi_cs_n)
    );
endmodule

// File: tb/tb_spi_hold_master.sv
`timescale 1ns/1ps
module tb_spi_hold_master;
    import spi_hold_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [0:0]  cs_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // Slave model and transition monitors
    logic [15:0] slv_sh = '0;
    logic [31:0] rx_cap = '0;
    int  rises = 0;
    int  cs_falls = 0;
    bit  fr_seen = 1'b0;
    time t_csf = 0, t_csr = 0, t_fr = 0, t_lr = 0, t_lf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hold_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    assign miso = slv_sh[15];

    always @(posedge sclk) begin
        rx_cap <= {rx_cap[30:0], mosi};
        rises  <= rises + 1;
        t_lr   <= $time;
        if (!fr_seen) begin
            t_fr    <= $time;
            fr_seen <= 1'b1;
        end
    end
    always @(negedge sclk) begin
        slv_sh <= {slv_sh[14:0], 1'b0};
        t_lf   <= $time;
    end
    always @(negedge cs_n[0]) begin
        t_csf    <= $time;
        cs_falls <= cs_falls + 1;
    end
    always @(posedge cs_n[0]) t_csr <= $time;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon(input logic [15:0] slave_bits);
        @(negedge clk);
        rises    = 0;
        cs_falls = 0;
        fr_seen  = 1'b0;
        rx_cap   = '0;
        slv_sh   = slave_bits;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek_now(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        peek_now(a, d);
    endtask

    task automatic drain(output logic [31:0] d);
        @(negedge clk);
        bus_addr = A_STAT; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_txspace();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            peek(A_STAT, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] txw(input logic [7:0] b, input logic [2:0] csn, input bit hold);
        return {7'b0, hold, 5'b0, csn, 8'b0, b};
    endfunction

    task automatic test_reset();
        logic [31:0] s;
        peek(A_STAT, s);
        chk("R1 reset status", s, 32'h2);
        chk("R1 reset cs idle", cs_n, 1'b1);
        chk("R3 reset sclk low", sclk, 1'b0);
    endtask

    task automatic test_held();
        logic [31:0] s;
        clear_mon(16'h0);
        wr(A_TXD, txw(8'hA5, 3'd0, 1'b0));
        repeat (50) @(negedge clk);
        peek(A_STAT, s);
        chk("R1 held write ignored", s[2:0], 3'b010);
        chk("R1 held no clock", rises, 0);
    endtask

    task automatic setup_cfg(input logic [7:0] p, input logic [7:0] d1, input logic [7:0] d2);
        wr(A_FMT, {24'b0, p});
        wr(A_DLY, {16'b0, d2, d1});
    endtask

    task automatic test_single();
        logic [31:0] s;
        setup_cfg(8'd3, 8'd5, 8'd4);
        clear_mon(16'h3C00);
        wr(A_TXD, txw(8'hA5, 3'd0, 1'b0));
        peek_now(A_STAT, s);
        chk("R2 tx full after write", s[0], 1'b1);
        repeat (120) @(negedge clk);
        chk("R3 eight rising edges", rises, 8);
        chk("R3 period T+1", t_lr - t_fr, 64'(7 * 4 * CLK_PERIOD));
        chk("R4 mosi msb first", rx_cap[7:0], 8'hA5);
        chk("R5 setup to first rise", t_fr - t_csf, 64'(7 * CLK_PERIOD));
        chk("R6 last fall to release", t_csr - t_lf, 64'(4 * CLK_PERIOD));
        peek(A_STAT, s);
        chk("R9 rx byte and flags", {s[15:8], s[2:0]}, {8'h3C, 3'b000});
        drain(s);
        peek(A_STAT, s);
        chk("R10 read sets empty", s[2:0], 3'b010);
    endtask

    task automatic test_fast();
        logic [31:0] s;
        setup_cfg(8'd0, 8'd0, 8'd0);
        clear_mon(16'hC300);
        wr(A_TXD, txw(8'h81, 3'd0, 1'b0));
        repeat (60) @(negedge clk);
        chk("R3 min period", t_lr - t_fr, 64'(7 * 2 * CLK_PERIOD));
        chk("R5 zero setup", t_fr - t_csf, 64'(CLK_PERIOD));
        chk("R6 zero tail", t_csr - t_lf, 64'(0));
        chk("R4 fast data out", rx_cap[7:0], 8'h81);
        drain(s);
        chk("R4 fast data in", s[15:8], 8'hC3);
    endtask

    task automatic test_backtoback();
        logic [31:0] s;
        setup_cfg(8'd3, 8'd5, 8'd4);
        clear_mon(16'h55AA);
        wr(A_TXD, txw(8'h12, 3'd0, 1'b1));
        wait_txspace();
        wr(A_TXD, txw(8'h34, 3'd0, 1'b0));
        repeat (200) @(negedge clk);
        chk("R7 sixteen edges", rises, 16);
        chk("R7 no gap between words", t_lr - t_fr, 64'(15 * 4 * CLK_PERIOD));
        chk("R7 one select pulse", cs_falls, 1);
        chk("R4 two words out", rx_cap[15:0], 16'h1234);
        peek(A_STAT, s);
        chk("R10 overrun keeps newest", {s[15:8], s[2:0]}, {8'hAA, 3'b100});
        drain(s);
        peek(A_STAT, s);
        chk("R10 read clears overrun", s[2:0], 3'b010);
    endtask

    task automatic test_hold_park();
        logic [31:0] s;
        clear_mon(16'h0);
        wr(A_TXD, txw(8'h0F, 3'd0, 1'b1));
        repeat (150) @(negedge clk);
        chk("R7 select parked low", cs_n, 1'b0);
        chk("R7 parked word edges", rises, 8);
        wr(A_TXD, txw(8'hF0, 3'd0, 1'b0));
        repeat (100) @(negedge clk);
        chk("R7 parked continues", rx_cap[7:0], 8'hF0);
        chk("R7 no second select pulse", cs_falls, 1);
        chk("R6 released after last", cs_n, 1'b1);
        drain(s);
    endtask

    task automatic test_full();
        logic [31:0] s;
        clear_mon(16'h0);
        wr(A_TXD, txw(8'h11, 3'd0, 1'b0));
        wait_txspace();
        wr(A_TXD, txw(8'h22, 3'd0, 1'b0));
        wr(A_TXD, txw(8'h33, 3'd0, 1'b0));
        peek(A_STAT, s);
        chk("R11 still full", s[0], 1'b1);
        repeat (250) @(negedge clk);
        chk("R11 two words only", rises, 16);
        chk("R11 dropped word absent", rx_cap[15:0], 16'h1122);
        drain(s);
    endtask

    task automatic test_switch();
        logic [31:0] s;
        clear_mon(16'h0);
        wr(A_TXD, txw(8'h99, 3'd0, 1'b1));
        wait_txspace();
        wr(A_TXD, txw(8'h66, 3'd1, 1'b0));
        repeat (250) @(negedge clk);
        chk("R12 both words sent", rises, 16);
        chk("R12 data order", rx_cap[15:0], 16'h9966);
        chk("R12 released before second", 64'(t_csr < t_lr), 64'(1));
        chk("R8 unmatched number asserts none", cs_falls, 1);
        chk("R12 idle after", cs_n, 1'b1);
        drain(s);
    endtask

    task automatic test_idle_level();
        logic [31:0] s;
        wr(A_IDLE, 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 idle level low", cs_n, 1'b0);
        wr(A_TXD, txw(8'h5A, 3'd0, 1'b0));
        repeat (12) @(negedge clk);
        chk("R8 asserted is inverse", cs_n, 1'b1);
        repeat (100) @(negedge clk);
        chk("R8 back to idle", cs_n, 1'b0);
        wr(A_IDLE, 32'h1);
        drain(s);
    endtask

    task automatic test_disable();
        logic [31:0] s;
        wr(A_CTRL0, 32'h0);
        clear_mon(16'h0);
        wr(A_TXD, txw(8'h77, 3'd0, 1'b0));
        repeat (50) @(negedge clk);
        peek(A_STAT, s);
        chk("R1 run cleared flags", s[2:0], 3'b010);
        chk("R1 run cleared no clock", rises, 0);
        chk("R1 run cleared select idle", cs_n, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        wr(A_CTRL1, 32'h3);
        test_held();
        wr(A_CTRL0, 32'h1);
        test_single();
        test_fast();
        test_backtoback();
        test_hold_park();
        test_full();
        test_switch();
        test_idle_level();
        test_disable();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule